// File: doc/BRIEF.md
# Prescaled reload timer

This block is an 8-bit up-counting timer driven by a divided copy of the processor clock. A free-running prescaler produces a one-cycle tick at one of eight ratios, chosen by a 3-bit rate code, and every tick advances the count by one while the timer runs. When the count steps from 0xFF to 0x00 it overflows. The overflow can raise a sticky interrupt request flag, and it can restore the count from a held start value so that the timer repeats on a fixed period.

Software sets the start value by writing the count. That write loads both the live count and the held start value. Software then sets the run bit together with the rate code, the auto-reload choice and the interrupt enable. The overflow period is (256 − start) ticks. For example, a start of 0x74 at the divide-by-64 rate on an 894.5 kHz processor clock gives about 10 ms. The run bit is the state of a two-state controller, STOP and RUN. A configuration write with the run bit set takes the start transition from STOP to RUN. A configuration write with the run bit clear takes the halt transition from RUN to STOP. Any other configuration write keeps the current state and only retunes the fields.

Top module: `tmr_reload_timer`

## Requirements
- R1: After reset, the run bit, rate code, auto-reload, interrupt enable and interrupt flag read 0, and the count and start value read 0x00.
- R2: The count changes only on a tick or on a count write. With no tick and no write, it holds its value, including in every cycle after a halt.
- R3: Rate code r gives a tick every 2^(8−r) cycles: code 0 divides by 256 and code 7 divides by 2. The prescaler is cleared while the timer is stopped. After a configuration write that starts the timer, the first count increment therefore lands on the 2^(8−r)-th clock edge after that write, and the following increments come at the same interval.
- R4: With auto-reload off, a tick at 0xFF wraps the count to 0x00, and counting continues upward from there.
- R5: With auto-reload on, a tick at 0xFF loads the held start value into the count in place of 0x00.
- R6: An overflow sets the interrupt flag when the interrupt enable is 1. With the interrupt enable at 0, an overflow leaves the flag unchanged.
- R7: The interrupt flag stays set until a clear strobe. If a clear and an overflow with the interrupt enable at 1 fall in the same cycle, the flag ends set.
- R8: A count write loads the written byte into both the count and the held start value on the next edge. If the write falls in the same cycle as a tick, the write takes precedence, and no increment and no overflow occur.
- R9: A configuration write stores the run bit, the rate code, auto-reload and the interrupt enable. These values read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit written by cfg_we |
| cfg_rate | input | 3 | Rate code written by cfg_we (0 = /256 … 7 = /2) |
| cfg_autoreload | input | 1 | Auto-reload enable written by cfg_we |
| cfg_irq_en | input | 1 | Interrupt enable written by cfg_we |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Byte loaded into the count and the start value |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| run_o | output | 1 | Run bit (controller in RUN) |
| rate_o | output | 3 | Stored rate code |
| autoreload_o | output | 1 | Stored auto-reload enable |
| irq_en_o | output | 1 | Stored interrupt enable |
| count_o | output | 8 | Live count |
| reload_o | output | 8 | Held start value |
| irq_flag_o | output | 1 | Sticky interrupt request flag |

## Verification
The properties assume that every strobe and data input has a known value from the first clock edge, and that reset is held with the strobes low until the counters have settled. They also assume that only the count write port alters the count outside a tick. The bench drives every input at the falling edge and holds reset with all strobes at 0 from time zero. It changes the rate code only through a configuration write that also starts or halts the timer, so a divide ratio never changes partway through a prescaler period that a check depends on.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DEF_CNT_W  = 8;
    localparam int unsigned DEF_RATE_W = 3;

    typedef enum logic {
        TMR_STOP = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE        = 3'd0,
        ACT_LOAD        = 3'd1,
        ACT_STEP        = 3'd2,
        ACT_WRAP_ZERO   = 3'd3,
        ACT_WRAP_RELOAD = 3'd4
    } cnt_act_e;

endpackage

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_run,
    output logic running
);

    tmr_state_e state_q;
    tmr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // start: STOP -> RUN on a configuration write with the run bit set
    // halt:  RUN -> STOP on a configuration write with the run bit clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_STOP: begin
                if (cfg_we && cfg_run) begin
                    state_d = TMR_RUN;
                end
            end
            TMR_RUN: begin
                if (cfg_we && !cfg_run) begin
                    state_d = TMR_STOP;
                end
            end
            default: state_d = TMR_STOP;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TMR_RUN:  running = 1'b1;
            default:  running = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int unsigned NRATES = 1 << RATE_W;
    localparam int unsigned PRE_W  = NRATES;

    logic [PRE_W-1:0]  pre_q;
    logic [NRATES-1:0] tap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!running) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Code g fires when the low (PRE_W - g) bits are all ones,
    // i.e. once every 2^(PRE_W - g) cycles.
    for (genvar g = 0; g < NRATES; g++) begin : g_tap
        assign tap[g] = &pre_q[PRE_W-1-g:0];
    end

    assign tick = running & tap[rate];

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             autoreload,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    cnt_act_e         act;

    always_comb begin
        if (wr_en) begin
            act = ACT_LOAD;
        end else if (tick && (count_q == CNT_MAX)) begin
            act = autoreload ? ACT_WRAP_RELOAD : ACT_WRAP_ZERO;
        end else if (tick) begin
            act = ACT_STEP;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    count_q  <= wr_data;
                    reload_q <= wr_data;
                end
                ACT_STEP:        count_q <= count_q + 1'b1;
                ACT_WRAP_ZERO:   count_q <= '0;
                ACT_WRAP_RELOAD: count_q <= reload_q;
                default:         count_q <= count_q;
            endcase
        end
    end

    assign wrap   = (act == ACT_WRAP_ZERO) || (act == ACT_WRAP_RELOAD);
    assign count  = count_q;
    assign reload = reload_q;

endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic irq_en,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap && irq_en) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/tmr_reload_timer.sv
module tmr_reload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_run,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_autoreload,
    input  logic              cfg_irq_en,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              flag_clr,
    output logic              run_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              autoreload_o,
    output logic              irq_en_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              irq_flag_o
);

    logic              running;
    logic              tick;
    logic              wrap;
    logic [RATE_W-1:0] rate_q;
    logic              autoreload_q;
    logic              irq_en_q;
    logic [CNT_W-1:0]  count_w;
    logic [CNT_W-1:0]  reload_w;
    logic              flag_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q       <= '0;
            autoreload_q <= 1'b0;
            irq_en_q     <= 1'b0;
        end else if (cfg_we) begin
            rate_q       <= cfg_rate;
            autoreload_q <= cfg_autoreload;
            irq_en_q     <= cfg_irq_en;
        end
    end

    tmr_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_run (cfg_run),
        .running (running)
    );

    tmr_prescaler #(
        .RATE_W (RATE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .rate    (rate_q),
        .tick    (tick)
    );

    tmr_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .autoreload (autoreload_q),
        .wr_en      (cnt_we),
        .wr_data    (cnt_wdata),
        .count      (count_w),
        .reload     (reload_w),
        .wrap       (wrap)
    );

    tmr_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .irq_en (irq_en_q),
        .clr    (flag_clr),
        .flag   (flag_w)
    );

    assign run_o        = running;
    assign rate_o       = rate_q;
    assign autoreload_o = autoreload_q;
    assign irq_en_o     = irq_en_q;
    assign count_o      = count_w;
    assign reload_o     = reload_w;
    assign irq_flag_o   = flag_w;

endmodule

// File: rtl/tmr_reload_timer_chk.sv
module tmr_reload_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             flag_clr,
    input logic             run_o,
    input logic             autoreload_o,
    input logic             irq_en_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] reload_o,
    input logic             irq_flag_o,
    input logic             tick,
    input logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && (count_o != CNT_MAX)) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(count_o));

    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_o);

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !autoreload_o) |=> (count_o == '0));

    a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && autoreload_o) |=> (count_o == $past(reload_o)));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && irq_en_o) |=> irq_flag_o);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag_o && !(wrap && irq_en_o)) |=> !irq_flag_o);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !flag_clr) |=> irq_flag_o);

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> ((count_o == $past(cnt_wdata)) && (reload_o == $past(cnt_wdata))));

endmodule

bind tmr_reload_timer tmr_reload_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_we       (cnt_we),
    .cnt_wdata    (cnt_wdata),
    .flag_clr     (flag_clr),
    .run_o        (run_o),
    .autoreload_o (autoreload_o),
    .irq_en_o     (irq_en_o),
    .count_o      (count_o),
    .reload_o     (reload_o),
    .irq_flag_o   (irq_flag_o),
    .tick         (tick),
    .wrap         (wrap)
);

// File: tb/test_tmr_reload_timer.sv
module test_tmr_reload_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_run = 1'b0;
    logic [2:0] cfg_rate = 3'd0;
    logic       cfg_autoreload = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = 8'd0;
    logic       flag_clr = 1'b0;
    logic       run_o;
    logic [2:0] rate_o;
    logic       autoreload_o;
    logic       irq_en_o;
    logic [7:0] count_o;
    logic [7:0] reload_o;
    logic       irq_flag_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_reload_timer i_tmr_reload_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_run        (cfg_run),
        .cfg_rate       (cfg_rate),
        .cfg_autoreload (cfg_autoreload),
        .cfg_irq_en     (cfg_irq_en),
        .cnt_we         (cnt_we),
        .cnt_wdata      (cnt_wdata),
        .flag_clr       (flag_clr),
        .run_o          (run_o),
        .rate_o         (rate_o),
        .autoreload_o   (autoreload_o),
        .irq_en_o       (irq_en_o),
        .count_o        (count_o),
        .reload_o       (reload_o),
        .irq_flag_o     (irq_flag_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_count(input int s, input int ar, input int inc);
        if (ar != 0) return s + (inc % (256 - s));
        return (s + inc) % 256;
    endfunction

    // One configuration of the rate sweep: halt, load start, start, observe.
    task automatic run_case(input int rate, input int ar, input int ie, input int s);
        int d;
        int n;
        int e;
        d = 256 >> rate;
        n = 12 * d + 3;
        cfg_we = 1'b1; cfg_run = 1'b0;
        step();
        cfg_we = 1'b0;
        flag_clr = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'(s);
        step();
        flag_clr = 1'b0; cnt_we = 1'b0;
        chk("R8", "count after write", count_o, s);
        chk("R8", "start value after write", reload_o, s);
        cfg_we = 1'b1; cfg_run = 1'b1; cfg_rate = 3'(rate);
        cfg_autoreload = 1'(ar); cfg_irq_en = 1'(ie);
        step();
        cfg_we = 1'b0;
        chk("R9", "run", run_o, 1);
        chk("R9", "rate", rate_o, rate);
        chk("R9", "autoreload", autoreload_o, ar);
        chk("R9", "irq_en", irq_en_o, ie);
        chk("R3", "count at start", count_o, s);
        for (int k = 1; k <= n; k++) begin
            step();
            chk(ar != 0 ? "R3/R5" : "R3/R4", $sformatf("count rate %0d cycle %0d", rate, k),
                count_o, exp_count(s, ar, k / d));
            chk("R6", $sformatf("flag rate %0d cycle %0d", rate, k),
                irq_flag_o, (ie != 0 && (k / d) >= 256 - s) ? 1 : 0);
        end
        cfg_we = 1'b1; cfg_run = 1'b0;
        step();
        cfg_we = 1'b0;
        e = exp_count(s, ar, (n + 1) / d);
        chk("R9", "run after halt", run_o, 0);
        chk("R3", "count at halt edge", count_o, e);
        for (int h = 0; h < 5; h++) begin
            step();
            chk("R2", "hold while stopped", count_o, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1", "run", run_o, 0);
        chk("R1", "rate", rate_o, 0);
        chk("R1", "autoreload", autoreload_o, 0);
        chk("R1", "irq_en", irq_en_o, 0);
        chk("R1", "count", count_o, 0);
        chk("R1", "start value", reload_o, 0);
        chk("R1", "flag", irq_flag_o, 0);
        step();
        chk("R2", "stopped count stays", count_o, 0);

        // Sweep every rate code with and without auto-reload.
        for (int r = 0; r < 8; r++) begin
            run_case(r, 1, (r % 2 == 0) ? 1 : 0, 8'hFC);
            run_case(r, 0, (r % 2 == 0) ? 0 : 1, 8'hFA);
        end

        // Directed sequence at code 7 (divide by 2): ticks land on even edges.
        cfg_we = 1'b1; cfg_run = 1'b0;
        step();
        cfg_we = 1'b0; flag_clr = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h40;
        step();
        flag_clr = 1'b0; cnt_we = 1'b0;
        cfg_we = 1'b1; cfg_run = 1'b1; cfg_rate = 3'd7;
        cfg_autoreload = 1'b1; cfg_irq_en = 1'b1;
        step();                                   // E0
        cfg_we = 1'b0;
        step();                                   // E1
        chk("R3", "no tick yet", count_o, 8'h40);
        cnt_we = 1'b1; cnt_wdata = 8'hFF;        // lands on tick edge E2
        step();                                   // E2
        cnt_we = 1'b0;
        chk("R8", "write beats tick", count_o, 8'hFF);
        chk("R8", "start value rewritten", reload_o, 8'hFF);
        chk("R8", "no overflow on write", irq_flag_o, 0);
        step();                                   // E3
        chk("R2", "no tick at odd edge", count_o, 8'hFF);
        step();                                   // E4 overflow
        chk("R5", "reload from written value", count_o, 8'hFF);
        chk("R6", "flag set on overflow", irq_flag_o, 1);
        flag_clr = 1'b1;
        step();                                   // E5 clear, no tick
        chk("R7", "flag cleared", irq_flag_o, 0);
        step();                                   // E6 clear with overflow
        flag_clr = 1'b0;
        chk("R7", "overflow wins over clear", irq_flag_o, 1);
        step();                                   // E7
        chk("R7", "flag sticky", irq_flag_o, 1);
        flag_clr = 1'b1;
        cfg_we = 1'b1; cfg_run = 1'b1; cfg_rate = 3'd7;
        cfg_autoreload = 1'b1; cfg_irq_en = 1'b0;
        step();                                   // E8 overflow, clear, retune
        flag_clr = 1'b0; cfg_we = 1'b0;
        chk("R7", "clear at overflow with enable still set", irq_flag_o, 1);
        chk("R9", "irq_en retuned off", irq_en_o, 0);
        chk("R9", "run kept on retune", run_o, 1);
        flag_clr = 1'b1;
        step();                                   // E9
        flag_clr = 1'b0;
        chk("R7", "flag cleared again", irq_flag_o, 0);
        step();                                   // E10 overflow, enable off
        chk("R6", "no flag with enable off", irq_flag_o, 0);
        chk("R5", "reload again", count_o, 8'hFF);
        step();
        step();                                   // E12 overflow
        chk("R6", "still no flag", irq_flag_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule